// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

This block merges five asynchronous reset request lines with the chip's active-low power-on reset. It drives one active-high system reset. Reset asserts combinationally the moment any request appears. Once every request has gone away, the block runs a staged release before letting the system run:

1. a slow delay, counted on a 1 kHz tick enable;
2. a fixed run of fast system clock cycles;
3. a wait for the oscillator-stable handshake;
4. a wait for the calibration-done handshake.

Any request seen during this sequence sends it back to the first stage.

A 2-bit start-up select chooses the length of the slow delay. A sticky cause register records every source that has requested reset. Software clears it with a write-one-to-clear strobe.

Top module: `reset_sequencer`

## Requirements
- R1: `rst_o` is high in the same cycle, before any clock edge, whenever `rst_ni` is low or any bit of `req_i` is high. It stays high while any of them stays active.
- R2: After all requests are removed, release runs in a fixed order: slow delay, fast count, oscillator wait, calibration wait. `rst_o` then falls at rising edge number Ls + FAST_CYC + 5 after the removal, where Ls is the slow length for the current select. This assumes `slow_tick_i`, `osc_stable_i` and `cal_done_i` are held high.
- R3: A request that appears during the release sequence restarts it. The full latency of R2 is then counted again from the removal of that request.
- R4: The slow stage advances only on cycles where `slow_tick_i` is high. With the tick held low, the sequence stays in that stage indefinitely.
- R5: `sut_i` selects Ls: 2'b00 = SLOW_LONG, 2'b01 = SLOW_SHORT, 2'b10 = SLOW_LONG, 2'b11 = 0 (the slow stage is skipped). `sut_i` is held stable during a sequence.
- R6: The fast stage lasts exactly FAST_CYC system clock cycles, whatever the select.
- R7: Release waits in one state for `osc_stable_i` and then in a second state for `cal_done_i`. If `osc_stable_i` rises while the sequence is waiting for it, `rst_o` falls at the second rising edge after the rise (with `cal_done_i` high). If `cal_done_i` rises while the sequence is waiting for it, `rst_o` falls at the first rising edge.
- R8: `cause_o` has one bit per source: bit 0 power-on, bit 1 = `req_i[0]` brown-out, bit 2 = `req_i[1]` watchdog, bit 3 = `req_i[2]` external pin, bit 4 = `req_i[3]` debug, bit 5 = `req_i[4]` software. A bit is set at the first rising edge where its request is high, and it stays set after the request goes away.
- R9: At a rising edge with `clr_stb_i` high, every `cause_o` bit whose `clr_mask_i` bit is 1 is cleared, unless its request is still high. An active request wins over the clear.
- R10: While `rst_ni` is low, `cause_o` equals 6'b000001. After `rst_ni` rises, release follows R2 from that moment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| req_i | input | 5 | Asynchronous reset requests: brown-out, watchdog, pin, debug, software |
| sut_i | input | 2 | Start-up delay select |
| slow_tick_i | input | 1 | One-cycle 1 kHz tick enable, synchronous to clk_i |
| osc_stable_i | input | 1 | Oscillator start-up done |
| cal_done_i | input | 1 | Oscillator calibration done |
| clr_stb_i | input | 1 | Cause register clear strobe |
| clr_mask_i | input | 6 | Write-one-to-clear mask for cause bits |
| rst_o | output | 1 | System reset, active high |
| cause_o | output | 6 | Sticky reset cause bits |

## Verification
Two functions can act on the same cause bit in one cycle: a source that is still requesting reset and a software clear strobe that covers that bit. The bench provokes this by holding the external request high while strobing an all-ones mask. It then expects that bit to survive while the bits of inactive sources are cleared. A second collision is a new request during the slow or fast count. Here the bench confirms that the measured release latency restarts in full from the later removal.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;
  localparam int NUM_REQ = 5;
  localparam int CAUSE_W = NUM_REQ + 1;

  typedef enum logic [2:0] {
    ST_HOLD, ST_SLOW, ST_FAST, ST_OSC, ST_CAL, ST_RUN
  } seq_state_e;

  typedef enum logic [1:0] {
    SUT_LONG  = 2'b00,
    SUT_SHORT = 2'b01,
    SUT_RSVD  = 2'b10,
    SUT_NONE  = 2'b11
  } sut_e;
endpackage

// File: rtl/rst_req_sync.sv
module rst_req_sync #(
  parameter int NUM_REQ = 5,
  parameter int STAGES  = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_REQ-1:0] req_i,
  output logic               req_any_o,
  output logic               hold_o
);
  logic             arst_n;
  logic [STAGES-1:0] sync_q;

  assign req_any_o = |req_i;
  assign arst_n    = rst_ni & ~req_any_o;

  // assert at once, release through STAGES flops
  always_ff @(posedge clk_i or negedge arst_n) begin
    if (!arst_n) sync_q <= '1;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b0};
  end

  assign hold_o = sync_q[STAGES-1];
endmodule

// File: rtl/rst_stage_fsm.sv
module rst_stage_fsm
  import rst_seq_pkg::*;
#(
  parameter int SLOW_LONG  = 65536,
  parameter int SLOW_SHORT = 4096,
  parameter int FAST_CYC   = 24
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       hold_i,
  input  logic [1:0] sut_i,
  input  logic       slow_tick_i,
  input  logic       osc_stable_i,
  input  logic       cal_done_i,
  output logic       run_o
);
  localparam int MAXC  = (SLOW_LONG > FAST_CYC) ? SLOW_LONG : FAST_CYC;
  localparam int CNT_W = $clog2(MAXC + 1);
  localparam logic [CNT_W-1:0] FAST_LAST = CNT_W'(FAST_CYC - 1);

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, slow_last;

  always_comb begin
    unique case (sut_e'(sut_i))
      SUT_SHORT: slow_last = CNT_W'(SLOW_SHORT - 1);
      default:   slow_last = CNT_W'(SLOW_LONG - 1);
    endcase
  end

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (hold_i) begin
      state_d = ST_HOLD;
      cnt_d   = '0;
    end else begin
      unique case (state_q)
        ST_HOLD: begin
          cnt_d   = '0;
          state_d = (sut_e'(sut_i) == SUT_NONE) ? ST_FAST : ST_SLOW;
        end
        ST_SLOW: if (slow_tick_i) begin
          if (cnt_q == slow_last) begin
            cnt_d   = '0;
            state_d = ST_FAST;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_FAST: begin
          if (cnt_q == FAST_LAST) begin
            cnt_d   = '0;
            state_d = ST_OSC;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_OSC:  if (osc_stable_i) state_d = ST_CAL;
        ST_CAL:  if (cal_done_i)   state_d = ST_RUN;
        default: state_d = ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_HOLD;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign run_o = (state_q == ST_RUN);

  a_r3_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> state_q == ST_HOLD);
  a_r2_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && $past(state_q) != ST_RUN) |-> $past(state_q) == ST_CAL);
  a_r4_slow_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SLOW && !slow_tick_i && !hold_i) |=> (state_q == ST_SLOW && $stable(cnt_q)));
  a_r7_osc_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_OSC && !osc_stable_i && !hold_i) |=> state_q == ST_OSC);
endmodule

// File: rtl/rst_cause_reg.sv
module rst_cause_reg #(
  parameter int NUM_REQ = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_REQ-1:0] req_i,
  input  logic               clr_stb_i,
  input  logic [NUM_REQ:0]   clr_mask_i,
  output logic [NUM_REQ:0]   cause_o
);
  logic [NUM_REQ:0] cause_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cause_q[0] <= 1'b1;
    else if (clr_stb_i && clr_mask_i[0]) cause_q[0] <= 1'b0;
  end

  for (genvar k = 0; k < NUM_REQ; k++) begin : g_src
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             cause_q[k+1] <= 1'b0;
      else if (req_i[k])                       cause_q[k+1] <= 1'b1;
      else if (clr_stb_i && clr_mask_i[k+1])   cause_q[k+1] <= 1'b0;
    end

    a_r8_sticky_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req_i[k] |=> cause_o[k+1]);
    a_r9_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_stb_i && clr_mask_i[k+1] && !req_i[k]) |=> !cause_o[k+1]);
  end

  assign cause_o = cause_q;
endmodule

// File: rtl/reset_sequencer.sv
module reset_sequencer
  import rst_seq_pkg::*;
#(
  parameter int SLOW_LONG  = 65536,
  parameter int SLOW_SHORT = 4096,
  parameter int FAST_CYC   = 24
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_REQ-1:0] req_i,
  input  logic [1:0]         sut_i,
  input  logic               slow_tick_i,
  input  logic               osc_stable_i,
  input  logic               cal_done_i,
  input  logic               clr_stb_i,
  input  logic [CAUSE_W-1:0] clr_mask_i,
  output logic               rst_o,
  output logic [CAUSE_W-1:0] cause_o
);
  logic req_any, hold, run;

  rst_req_sync #(.NUM_REQ(NUM_REQ), .STAGES(2)) i_sync (
    .clk_i, .rst_ni, .req_i, .req_any_o(req_any), .hold_o(hold)
  );

  rst_stage_fsm #(
    .SLOW_LONG(SLOW_LONG), .SLOW_SHORT(SLOW_SHORT), .FAST_CYC(FAST_CYC)
  ) i_fsm (
    .clk_i, .rst_ni, .hold_i(hold), .sut_i, .slow_tick_i,
    .osc_stable_i, .cal_done_i, .run_o(run)
  );

  rst_cause_reg #(.NUM_REQ(NUM_REQ)) i_cause (
    .clk_i, .rst_ni, .req_i, .clr_stb_i, .clr_mask_i, .cause_o
  );

  assign rst_o = ~rst_ni | req_any | ~run;

  a_r1_release_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rst_o) |-> !(|req_i));
  a_r1_req_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|req_i) |-> rst_o);
endmodule

// File: tb/test_reset_sequencer.sv
module test_reset_sequencer;
  localparam int LNG = 20;
  localparam int SHT = 6;
  localparam int FST = 4;

  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic [4:0] req_i;
  logic [1:0] sut_i;
  logic       slow_tick_i, osc_stable_i, cal_done_i, clr_stb_i;
  logic [5:0] clr_mask_i;
  logic       rst_o;
  logic [5:0] cause_o;
  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  reset_sequencer #(.SLOW_LONG(LNG), .SLOW_SHORT(SHT), .FAST_CYC(FST)) i_reset_sequencer (
    .clk_i, .rst_ni, .req_i, .sut_i, .slow_tick_i, .osc_stable_i, .cal_done_i,
    .clr_stb_i, .clr_mask_i, .rst_o, .cause_o
  );

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int slow_len(input logic [1:0] s);
    return (s == 2'b11) ? 0 : (s == 2'b01) ? SHT : LNG;
  endfunction

  // rising edges until rst_o is seen low
  task automatic measure(output int n);
    n = 0;
    do begin
      @(posedge clk_i); #1; n++;
    end while (rst_o && n < 1000);
  endtask

  task automatic clear_all();
    @(negedge clk_i); clr_stb_i = 1'b1; clr_mask_i = 6'h3f;
    @(negedge clk_i); clr_stb_i = 1'b0; clr_mask_i = '0;
  endtask

  initial begin
    int n;
    rst_ni = 1'b0; req_i = '0; sut_i = 2'b00; slow_tick_i = 1'b1;
    osc_stable_i = 1'b1; cal_done_i = 1'b1; clr_stb_i = 1'b0; clr_mask_i = '0;
    #1 chk("R1 por rst_o", rst_o, 1);
    @(negedge clk_i); @(negedge clk_i);
    chk("R10 por cause", cause_o, 6'b000001);
    rst_ni = 1'b1;
    measure(n);
    chk("R10 por release latency", n, LNG + FST + 5);

    clear_all();
    chk("R9 clear all", cause_o, 0);

    for (int s = 0; s < 4; s++) begin
      for (int src = 0; src < 5; src++) begin
        @(negedge clk_i);
        sut_i = 2'(s);
        req_i = 5'(1 << src);
        #1 chk("R1 immediate assert", rst_o, 1);
        @(negedge clk_i); @(negedge clk_i);
        chk("R8 cause bit", cause_o, 1 << (src + 1));
        req_i = '0;
        measure(n);
        chk("R2 R5 R6 latency", n, slow_len(2'(s)) + FST + 5);
        chk("R8 sticky after release", cause_o, 1 << (src + 1));
        clear_all();
      end
    end

    // R3 restart during slow and during fast stage
    for (int w = 3; w <= SHT + 5; w += SHT + 2) begin
      @(negedge clk_i); sut_i = 2'b01; req_i = 5'b00001;
      @(negedge clk_i); req_i = '0;
      repeat (w) @(negedge clk_i);
      chk("R3 still in reset", rst_o, 1);
      req_i = 5'b10000;
      #1 chk("R3 new request asserts", rst_o, 1);
      @(negedge clk_i); @(negedge clk_i); req_i = '0;
      measure(n);
      chk("R3 full restart latency", n, SHT + FST + 5);
    end
    clear_all();

    // R4 slow tick gating
    @(negedge clk_i); sut_i = 2'b01; slow_tick_i = 1'b0; req_i = 5'b00100;
    @(negedge clk_i); req_i = '0;
    repeat (50) @(negedge clk_i);
    chk("R4 no tick holds reset", rst_o, 1);
    slow_tick_i = 1'b1;
    measure(n);
    chk("R4 tick resume latency", n, SHT + FST + 2);

    // R7 oscillator handshake
    @(negedge clk_i); sut_i = 2'b11; osc_stable_i = 1'b0; req_i = 5'b00010;
    @(negedge clk_i); req_i = '0;
    repeat (30) @(negedge clk_i);
    chk("R7 osc wait", rst_o, 1);
    osc_stable_i = 1'b1;
    measure(n);
    chk("R7 osc latency", n, 2);

    // R7 calibration handshake
    @(negedge clk_i); cal_done_i = 1'b0; req_i = 5'b01000;
    @(negedge clk_i); req_i = '0;
    repeat (30) @(negedge clk_i);
    chk("R7 cal wait", rst_o, 1);
    cal_done_i = 1'b1;
    measure(n);
    chk("R7 cal latency", n, 1);
    clear_all();

    // R9 active request beats clear; partial mask
    @(negedge clk_i); req_i = 5'b00001;
    @(negedge clk_i); req_i = 5'b00100;
    @(negedge clk_i); clr_stb_i = 1'b1; clr_mask_i = 6'h3f;
    @(negedge clk_i); clr_stb_i = 1'b0; clr_mask_i = '0;
    chk("R9 set wins over clear", cause_o, 6'b001000);
    req_i = 5'b10001;
    @(negedge clk_i); req_i = '0;
    @(negedge clk_i); clr_stb_i = 1'b1; clr_mask_i = 6'b000010;
    @(negedge clk_i); clr_stb_i = 1'b0; clr_mask_i = '0;
    chk("R9 partial mask", cause_o, 6'b101000);
    measure(n);
    chk("R2 final release", rst_o, 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule